// File: doc/BRIEF.md
# Synchronous Burst Memory Controller

This block connects an internal request stream to one external synchronous burst memory. A request names a start address, a direction and a burst length of one to eight beats. The controller selects the device, sends one burst-start pulse with the start address, keeps the read or write strobe active, and moves one data word on each clock in which a beat completes. Write words come in on a valid/ready stream. Read words go out on a valid-only stream. A single done pulse marks the end of each request.

The memory can pull an active-low hold input during a burst. This input is used only when synchronous operation is enabled. A mode bit sets the response. In restart mode the controller drops the current burst and opens a new one at the first word not yet moved. In wait mode it stalls the beats and carries on with the same burst after the memory releases the input. The high external address bits come either straight from the internal address or from the internal address shifted right by the memory width in bytes.

The request stream accepts when `req_valid` and `req_ready` are both high. The write stream accepts when `wr_valid` and `wr_ready` are both high. A write beat waits for `wr_valid`. The read stream has no back-pressure, because a burst memory cannot be paused on the read side except through its own hold input. The consumer must take every `rd_valid` word.

Top module: `sbm_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe`, `rd_valid` and `done` are low, and `req_ready` is high.
- R2: A request accepted in cycle t gives `mem_adv_n` low for exactly one cycle at t+1, with `mem_cs_n` low and `mem_addr_lo` equal to the low 16 address bits. It then moves `req_len`+1 beats, where the length field value 0..7 means 1..8 beats.
- R3: During a write burst, `mem_we_n` is low and `mem_dq_oe` is high from the burst-start cycle to the last beat. `wr_ready` is high only in transfer cycles that are not held. `mem_dq_out` carries `wr_data`, and a beat completes only when `wr_valid` is high.
- R4: During a read burst, `mem_oe_n` is low. Each completed beat samples `mem_dq_in`, and the next cycle shows that word on `rd_data` with `rd_valid` high.
- R5: `done` pulses for one cycle, in the cycle after the last beat of a request.
- R6: With `cfg_sync` low, `mem_ecb_n` has no effect on beats, strobes or burst-start pulses.
- R7: With `cfg_sync` high and `cfg_wait_mode` = 1, a low `mem_ecb_n` in a transfer cycle completes no beat and drops `wr_ready`. The burst then continues with no new burst-start pulse.
- R8: With `cfg_sync` high and `cfg_wait_mode` = 0, a low `mem_ecb_n` in a transfer cycle completes no beat. The next cycle is a new burst-start pulse whose address is that of the first word not yet moved.
- R9: `req_ready` is also high in the cycle of the last beat. A request accepted there starts its burst in the next cycle with no idle cycle between bursts. For a write, `mem_we_n` is already low in that burst-start cycle, so the first word is written.
- R10: With `cfg_unshift` = 1, `mem_addr_hi` equals internal address bits [25:16], every bit included.
- R11: With `cfg_unshift` = 0, `mem_addr_hi` equals internal bits [25:16], [26:17] or [27:18] for `cfg_width` 0 (byte), 1 (half-word) or 2 and 3 (word). The beat address advances by 1, 2 or 4 bytes for the same encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | Enables use of the hold input |
| cfg_wait_mode | input | 1 | 1: hold inserts wait states; 0: hold ends the burst and restarts it |
| cfg_unshift | input | 1 | 1: high address bits taken unshifted |
| cfg_width | input | 2 | Memory width: 0 byte, 1 half-word, 2/3 word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 for a write request |
| req_addr | input | 28 | Byte start address |
| req_len | input | 3 | Beats minus one |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word taken when valid |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| done | output | 1 | Request finished |
| mem_cs_n | output | 1 | Device select, active low |
| mem_adv_n | output | 1 | Burst-start pulse, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr_hi | output | 10 | High external address bits |
| mem_addr_lo | output | 16 | Low external address bits |
| mem_dq_out | output | 32 | Data to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 32 | Data from memory |
| mem_ecb_n | input | 1 | Hold / end-of-burst from memory, active low |

## Verification
The bench aims at these corner cases:
- Hold asserted in the very first transfer cycle of a burst, and hold asserted two cycles in a row.
- A gap in write data that lands on a hold.
- Requests queued back to back, including single-beat bursts.

A controller that restarts in wait mode, or fails to restart in restart mode, shows an extra or a missing burst-start pulse, or the wrong address at the pulse. A late write strobe after a back-to-back hand-over, or a second start pulse, shows up in the per-cycle comparison of `mem_we_n` and `mem_adv_n`. A mapping that drops bit 23, or shifts by the wrong width, shows up at a start address with that bit set, under each width setting.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_XFER  = 2'd2
  } sbm_state_e;
endpackage

// File: rtl/sbm_addr_map.sv
// Forms the high external address bits from a window of the internal address.
module sbm_addr_map #(
  parameter int HI_W = 10
) (
  input  logic [HI_W+1:0] addr_win,  // internal bits starting at the high field LSB
  input  logic            unshift,
  input  logic [1:0]      shamt,     // 0, 1 or 2
  output logic [HI_W-1:0] addr_hi
);
  for (genvar i = 0; i < HI_W; i++) begin : g_bit
    assign addr_hi[i] = unshift         ? addr_win[i]   :
                        (shamt == 2'd2) ? addr_win[i+2] :
                        (shamt == 2'd1) ? addr_win[i+1] :
                                          addr_win[i];
  end
endmodule

// File: rtl/sbm_beat_ctr.sv
// Counts the beats left in a request; last is high on the final one.
module sbm_beat_ctr #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] left_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_m1 <= '0;
    else if (load) left_m1 <= load_len;
    else if (dec)  left_m1 <= left_m1 - 1'b1;
  end

  assign last = (left_m1 == '0);
endmodule

// File: rtl/sbm_seq.sv
// Burst sequencer: idle, burst-start pulse, transfer.
module sbm_seq
  import sbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       beat,
  input  logic       last,
  input  logic       restart,
  output sbm_state_e state
);
  sbm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req_fire) nxt = ST_START;
      ST_START: nxt = ST_XFER;
      ST_XFER: begin
        if (beat && last) nxt = req_fire ? ST_START : ST_IDLE;
        else if (restart) nxt = ST_START;
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3,
  parameter int HI_LSB = 16,
  parameter int HI_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync,
  input  logic              cfg_wait_mode,
  input  logic              cfg_unshift,
  input  logic [1:0]        cfg_width,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [HI_W-1:0]   mem_addr_hi,
  output logic [HI_LSB-1:0] mem_addr_lo,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_ecb_n
);
  localparam int WIN_W = HI_W + 2;

  sbm_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_q;
  logic              last;
  logic              hold, in_xfer, beat, req_fire, restart;
  logic [1:0]        shamt;
  logic [ADDR_W-1:0] step;

  // Width 3 behaves as word-wide.
  assign shamt   = cfg_width[1] ? 2'd2 : {1'b0, cfg_width[0]};
  assign step    = ADDR_W'(1) << shamt;

  assign hold      = cfg_sync & ~mem_ecb_n;
  assign in_xfer   = (state == ST_XFER);
  assign beat      = in_xfer & ~hold & (~wr_q | wr_valid);
  assign req_ready = (state == ST_IDLE) | (beat & last);
  assign req_fire  = req_valid & req_ready;
  assign restart   = in_xfer & hold & ~cfg_wait_mode;

  sbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .beat(beat),
    .last(last), .restart(restart), .state(state)
  );

  sbm_beat_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .load_len(req_len),
    .dec(beat & ~req_fire), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      wr_q     <= 1'b0;
    end else if (req_fire) begin
      cur_addr <= req_addr;
      wr_q     <= req_write;
    end else if (beat) begin
      cur_addr <= cur_addr + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= beat & ~wr_q;
      done     <= beat & last;
      if (beat & ~wr_q) rd_data <= mem_dq_in;
    end
  end

  sbm_addr_map #(.HI_W(HI_W)) u_map (
    .addr_win(cur_addr[HI_LSB +: WIN_W]), .unshift(cfg_unshift),
    .shamt(shamt), .addr_hi(mem_addr_hi)
  );

  assign mem_addr_lo = cur_addr[HI_LSB-1:0];
  assign mem_cs_n    = (state == ST_IDLE);
  assign mem_adv_n   = (state != ST_START);
  assign mem_we_n    = ~((state != ST_IDLE) & wr_q);
  assign mem_oe_n    = ~((state != ST_IDLE) & ~wr_q);
  assign mem_dq_oe   = (state != ST_IDLE) & wr_q;
  assign mem_dq_out  = wr_data;
  assign wr_ready    = in_xfer & wr_q & ~hold;
endmodule

// File: rtl/sbm_ctrl_chk.sv
module sbm_ctrl_chk #(
  parameter int ADDR_W = 28,
  parameter int HI_LSB = 16,
  parameter int HI_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sync,
  input logic              cfg_wait_mode,
  input logic              cfg_unshift,
  input logic [1:0]        cfg_width,
  input logic              mem_ecb_n,
  input logic              mem_cs_n,
  input logic              mem_adv_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              rd_valid,
  input logic              wr_ready,
  input logic              done,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [HI_W-1:0]   mem_addr_hi
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_adv_n && mem_we_n && mem_oe_n)); // R1
  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_WAIT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync && cfg_wait_mode && !mem_ecb_n && !mem_cs_n && mem_adv_n) |-> !wr_ready); // R7
  AST_WAIT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync && cfg_wait_mode && !mem_ecb_n && !mem_cs_n && mem_adv_n)
      |=> (!rd_valid && mem_adv_n && !mem_cs_n)); // R7
  AST_END_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync && !cfg_wait_mode && !mem_ecb_n && !mem_cs_n && mem_adv_n) |=> !mem_adv_n); // R8
  AST_UNSHIFT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unshift |-> (mem_addr_hi == cur_addr[HI_LSB +: HI_W])); // R10
  AST_WORD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unshift && cfg_width[1]) |-> (mem_addr_hi == cur_addr[HI_LSB+2 +: HI_W])); // R11
endmodule

bind sbm_ctrl sbm_ctrl_chk #(.ADDR_W(ADDR_W), .HI_LSB(HI_LSB), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_wait_mode(cfg_wait_mode),
  .cfg_unshift(cfg_unshift), .cfg_width(cfg_width), .mem_ecb_n(mem_ecb_n),
  .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .rd_valid(rd_valid), .wr_ready(wr_ready), .done(done), .cur_addr(cur_addr),
  .mem_addr_hi(mem_addr_hi)
);

// File: tb/sbm_ctrl_test.sv
`timescale 1ns/1ps
module sbm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sync = 1'b1, cfg_wait_mode = 1'b1, cfg_unshift = 1'b1;
  logic [1:0]  cfg_width = 2'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic        wr_valid = 1'b1;
  logic [31:0] wr_data = '0, mem_dq_in = '0;
  logic        mem_ecb_n = 1'b1;
  logic        req_ready, wr_ready, rd_valid, done;
  logic        mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [31:0] rd_data, mem_dq_out;
  logic [9:0]  mem_addr_hi;
  logic [15:0] mem_addr_lo;

  sbm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_wait_mode(cfg_wait_mode),
    .cfg_unshift(cfg_unshift), .cfg_width(cfg_width), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr_hi(mem_addr_hi),
    .mem_addr_lo(mem_addr_lo), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ecb_n(mem_ecb_n)
  );

  always #5 clk = ~clk;

  typedef struct { bit w; logic [27:0] a; int len; } req_t;
  req_t req_q[$];
  bit   ecb_q[$];
  bit   wv_q[$];

  int checks = 0, failures = 0, advcnt = 0, cslow = 0, rdcnt = 0, cycn = 0;

  // behavioural reference state
  int          m_st = 0;   // 0 idle, 1 burst start, 2 transfer
  logic [27:0] m_addr = '0;
  int          m_left = 0;
  bit          m_wr = 0, m_rdv = 0, m_done = 0;
  logic [31:0] m_rdd = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit w, input logic [27:0] a, input int len);
    req_t r;
    r.w = w; r.a = a; r.len = len;
    req_q.push_back(r);
  endtask

  task automatic cyc();
    bit hold, beat, rdy, acc;
    int w;
    mem_ecb_n = (ecb_q.size() != 0) ? ecb_q.pop_front() : 1'b1;
    wr_valid  = (wv_q.size() != 0) ? wv_q.pop_front() : 1'b1;
    cycn++;
    mem_dq_in = 32'h5A5A0000 ^ (cycn * 32'h00010103);
    wr_data   = 32'hC0DE0000 + cycn;
    if (!req_valid && req_q.size() != 0) begin
      req_t r;
      r = req_q.pop_front();
      req_valid = 1'b1; req_write = r.w; req_addr = r.a; req_len = r.len[2:0];
    end
    #1;
    w    = (cfg_width == 2'd3) ? 2 : int'(cfg_width);
    hold = cfg_sync && !mem_ecb_n;
    beat = (m_st == 2) && !hold && (!m_wr || wr_valid);
    rdy  = (m_st == 0) || (beat && m_left == 1);
    acc  = req_valid && rdy;
    chk("R2", "cs_n", 32'(mem_cs_n), 32'(m_st == 0));
    chk("R2", "adv_n", 32'(mem_adv_n), 32'(m_st != 1));
    chk("R3", "we_n", 32'(mem_we_n), 32'(!(m_st != 0 && m_wr)));
    chk("R4", "oe_n", 32'(mem_oe_n), 32'(!(m_st != 0 && !m_wr)));
    chk("R3", "dq_oe", 32'(mem_dq_oe), 32'(m_st != 0 && m_wr));
    chk("R7", "wr_ready", 32'(wr_ready), 32'(m_st == 2 && m_wr && !hold));
    chk("R9", "req_ready", 32'(req_ready), 32'(rdy));
    chk("R4", "rd_valid", 32'(rd_valid), 32'(m_rdv));
    if (m_rdv) chk("R4", "rd_data", rd_data, m_rdd);
    chk("R5", "done", 32'(done), 32'(m_done));
    if (m_st == 1) begin
      chk("R2", "addr_lo", 32'(mem_addr_lo), 32'(m_addr[15:0]));
      if (cfg_unshift) chk("R10", "addr_hi", 32'(mem_addr_hi), 32'((m_addr >> 16) & 28'h3FF));
      else             chk("R11", "addr_hi", 32'(mem_addr_hi), 32'((m_addr >> (16 + w)) & 28'h3FF));
    end
    if (wr_ready && wr_valid) chk("R3", "dq_out", mem_dq_out, wr_data);
    if (!mem_adv_n) advcnt++;
    if (!mem_cs_n)  cslow++;
    if (rd_valid)   rdcnt++;
    @(posedge clk);
    m_rdv  = beat && !m_wr;
    m_rdd  = mem_dq_in;
    m_done = beat && (m_left == 1);
    case (m_st)
      0: if (acc) begin
           m_st = 1; m_addr = req_addr; m_left = int'(req_len) + 1; m_wr = req_write;
         end
      1: m_st = 2;
      default: begin
        if (beat) begin
          m_addr = m_addr + (28'd1 << w);
          m_left--;
          if (m_left == 0) begin
            if (acc) begin
              m_st = 1; m_addr = req_addr; m_left = int'(req_len) + 1; m_wr = req_write;
            end else m_st = 0;
          end
        end else if (hold && !cfg_wait_mode) m_st = 1;
      end
    endcase
    @(negedge clk);
    if (acc) req_valid = 1'b0;
  endtask

  task automatic run();
    advcnt = 0; cslow = 0; rdcnt = 0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (m_st == 0 && !req_valid && req_q.size() == 0 && !m_rdv && !m_done) break;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cs_n", 32'(mem_cs_n), 32'd1);
    chk("R1", "adv_n", 32'(mem_adv_n), 32'd1);
    chk("R1", "strobes", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
    chk("R1", "dq_oe", 32'(mem_dq_oe), 32'd0);
    rst_n = 1'b1;
    #1;
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    @(negedge clk);

    // R10: unshifted, bit 23 set; write then read
    push(1'b1, 28'h0A54320, 3);
    push(1'b0, 28'hF80_0000, 7);
    run();

    // R7: wait mode, two hold cycles in a read
    ecb_q = '{1, 1, 1, 0, 0};
    push(1'b0, 28'h0123450, 3);
    run();
    chk("R7", "burst starts", advcnt, 1);
    chk("R7", "read beats", rdcnt, 4);

    // R7: wait-mode write with hold and a data gap, shifted word map
    cfg_unshift = 1'b0;
    ecb_q = '{1, 1, 1, 0, 0, 0};
    wv_q  = '{1, 1, 1, 1, 1, 0, 1};
    push(1'b1, 28'hE9A_5500, 4);
    run();
    chk("R7", "write burst starts", advcnt, 1);

    // R8: restart mode, hold after two write beats
    cfg_wait_mode = 1'b0;
    ecb_q = '{1, 1, 1, 1, 0};
    push(1'b1, 28'h7C0_0010, 3);
    run();
    chk("R8", "burst starts", advcnt, 2);

    // R8: hold in the first transfer cycle of a read, half-word
    cfg_width = 2'd1;
    ecb_q = '{1, 1, 0};
    push(1'b0, 28'h5B3_0002, 2);
    run();
    chk("R8", "burst starts first", advcnt, 2);
    chk("R8", "read beats", rdcnt, 3);

    // R6: hold ignored when synchronous use is off
    cfg_sync = 1'b0;
    cfg_width = 2'd0;
    ecb_q = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    push(1'b0, 28'h3FF_FFF0, 2);
    run();
    chk("R6", "burst starts", advcnt, 1);
    chk("R6", "read beats", rdcnt, 3);
    ecb_q.delete();

    // R9: back-to-back bursts, no idle gap
    cfg_sync = 1'b1;
    cfg_width = 2'd3;
    push(1'b1, 28'h1234_560, 1);
    push(1'b1, 28'h8800_004, 0);
    push(1'b0, 28'hC4F_00A0, 0);
    run();
    chk("R9", "burst starts", advcnt, 3);
    chk("R9", "select-low cycles", cslow, 7);

    summary();
    $finish;
  end
endmodule